// File: doc/BRIEF.md
# Timer Unit Shared Core: Prescaler and Free-Running Counter

This block is the common section of an eight-channel timer unit. It holds two control registers. The configuration word gates the prescaler and the free-running counter. The reload word holds the prescale value N. From these it produces a single-cycle tick every N+1 clocks. Every timer channel advances on that tick, so no channel moves while the prescaler gate is off. The eight channel interrupt lines come back into the block and are shown both as one combined line and as a readable status word.

The block also holds a 64-bit counter that runs at the undivided clock while its gate bit is set. Software reads it over a 32-bit register port in two halves, low word first. Reading the low word captures the upper half into a shadow. The high-word read that follows then belongs to the same 64-bit sample, even when a carry crossed the word boundary between the two accesses.

Two small state machines carry the behaviour. The prescaler machine has the states PS_OFF and PS_RUN. It moves from PS_OFF to PS_RUN when the prescaler gate is seen set, and from PS_RUN back to PS_OFF when the gate is seen clear. Inside PS_RUN its divide count restarts after each tick. The split-read machine has the states SR_IDLE and SR_HELD. A low-word read moves it from SR_IDLE to SR_HELD, and a low-word read in SR_HELD recaptures the shadow and stays there. A high-word read in SR_HELD returns the shadow and moves it back to SR_IDLE.

Top module: `tmr_shared_core`

## Requirements
- R1: After reset the configuration and reload words are 0, tick_o is low, reg_rdata is 0 and the counter holds the value of parameter COUNT_INIT.
- R2: The configuration word is at offset 0x08. Bit 0 gates the counter and bit 2 gates the prescaler. Other bits read back as 0, and a write takes effect from the next cycle.
- R3: The reload word at offset 0x04 stores all 32 bits of the prescale value N and reads back unchanged.
- R4: While the prescaler is enabled, tick_o is high for exactly one cycle in every N+1 cycles. The first tick comes N+1 cycles after the PS_OFF to PS_RUN transition.
- R5: tick_o stays low whenever configuration bit 2 is clear. Disabling returns the machine to PS_OFF and clears the divide count, so re-enabling restarts the phase from zero.
- R6: If N is lowered to or below the current divide count, the tick fires in the first cycle the new value is in effect, and the count then restarts.
- R7: While configuration bit 0 is set, the counter increases by exactly one every clock. While the bit is clear, the counter holds its value.
- R8: The counter wraps from 2^64-1 to 0.
- R9: A read of offset 0x10 returns counter bits 31:0 and captures bits 63:32 into the shadow (SR_IDLE or SR_HELD to SR_HELD). A read of 0x14 in SR_HELD returns the shadow and goes to SR_IDLE. A read of 0x14 in SR_IDLE returns the live bits 63:32.
- R10: irq_any_o is the OR of the eight chan_irq lines. A read of offset 0x0C returns chan_irq in bits 7:0, with all other bits 0.
- R11: reg_rdata is updated on the clock edge that samples reg_rd and holds its value while reg_rd is low. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| chan_irq | input | 8 | Per-channel interrupt lines |
| tick_o | output | 1 | Prescaled tick to the channels |
| irq_any_o | output | 1 | OR of all channel interrupts |

## Verification
Suppose the prescaler machine holds a wrong divide count or state. Then the interval from enable to the first tick_o, or the interval between ticks, is wrong, and this shows within N+2 cycles of the enable write. Suppose instead the split-read machine or its shadow is wrong. Then a high-word read taken just after a carry out of the low word returns the new upper half instead of the captured one, or a high-word read in SR_IDLE returns a stale upper half. Both show at reg_rdata one cycle after the read. A counter that skips or creeps while gated off differs from the model on the next low-word read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        PS_OFF = 1'b0,
        PS_RUN = 1'b1
    } ps_state_t;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_HELD = 1'b1
    } sr_state_t;

    localparam int unsigned OFF_RELOAD = 4;
    localparam int unsigned OFF_CONFIG = 8;
    localparam int unsigned OFF_IRQ    = 12;
    localparam int unsigned OFF_CNT_LO = 16;
    localparam int unsigned OFF_CNT_HI = 20;

    localparam int unsigned CFG_CNT_BIT = 0;
    localparam int unsigned CFG_PS_BIT  = 2;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int unsigned DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    ps_state_t        state_q;
    logic [DIV_W-1:0] div_q;
    logic             hit;

    // state register and divide count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            div_q   <= '0;
        end else begin
            unique case (state_q)
                PS_OFF: begin
                    div_q <= '0;
                    if (enable) begin
                        state_q <= PS_RUN;
                    end
                end
                PS_RUN: begin
                    if (!enable) begin
                        state_q <= PS_OFF;
                        div_q   <= '0;
                    end else if (hit) begin
                        div_q <= '0;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= PS_OFF;
                    div_q   <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        hit  = (state_q == PS_RUN) && (div_q >= divisor);
        tick = hit && enable;
    end

endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
    import tmr_pkg::*;
#(
    parameter int unsigned                  WORD_W     = 32,
    parameter logic [2*WORD_W-1:0]          COUNT_INIT = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                count_en,
    input  logic                lo_rd,
    input  logic                hi_rd,
    output logic [WORD_W-1:0]   lo_word,
    output logic [WORD_W-1:0]   hi_word,
    output logic [2*WORD_W-1:0] count
);

    localparam int unsigned CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0]  count_q;
    logic [WORD_W-1:0] shadow_q;
    sr_state_t         state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= COUNT_INIT;
        end else if (count_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    // split-read state register and shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SR_IDLE;
            shadow_q <= '0;
        end else begin
            unique case (state_q)
                SR_IDLE: begin
                    if (lo_rd) begin
                        shadow_q <= count_q[CNT_W-1:WORD_W];
                        state_q  <= SR_HELD;
                    end
                end
                SR_HELD: begin
                    if (lo_rd) begin
                        shadow_q <= count_q[CNT_W-1:WORD_W];
                    end else if (hi_rd) begin
                        state_q <= SR_IDLE;
                    end
                end
                default: state_q <= SR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        lo_word = count_q[WORD_W-1:0];
        hi_word = (state_q == SR_HELD) ? shadow_q : count_q[CNT_W-1:WORD_W];
        count   = count_q;
    end

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] chan_irq,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output logic              lo_rd,
    output logic              hi_rd,
    output logic              cnt_en,
    output logic              ps_en,
    output logic [WORD_W-1:0] reload
);

    logic              cnt_en_q;
    logic              ps_en_q;
    logic [WORD_W-1:0] reload_q;
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_q <= 1'b0;
            ps_en_q  <= 1'b0;
            reload_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFF_CONFIG)) begin
                cnt_en_q <= reg_wdata[CFG_CNT_BIT];
                ps_en_q  <= reg_wdata[CFG_PS_BIT];
            end
            if (reg_addr == ADDR_W'(OFF_RELOAD)) begin
                reload_q <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= '0;
            if (reg_addr == ADDR_W'(OFF_CONFIG)) begin
                rdata_q[CFG_CNT_BIT] <= cnt_en_q;
                rdata_q[CFG_PS_BIT]  <= ps_en_q;
            end
            if (reg_addr == ADDR_W'(OFF_RELOAD)) rdata_q <= reload_q;
            if (reg_addr == ADDR_W'(OFF_IRQ))    rdata_q <= WORD_W'(chan_irq);
            if (reg_addr == ADDR_W'(OFF_CNT_LO)) rdata_q <= lo_word;
            if (reg_addr == ADDR_W'(OFF_CNT_HI)) rdata_q <= hi_word;
        end
    end

    always_comb begin
        lo_rd     = reg_rd && (reg_addr == ADDR_W'(OFF_CNT_LO));
        hi_rd     = reg_rd && (reg_addr == ADDR_W'(OFF_CNT_HI));
        cnt_en    = cnt_en_q;
        ps_en     = ps_en_q;
        reload    = reload_q;
        reg_rdata = rdata_q;
    end

endmodule

// File: rtl/tmr_shared_core.sv
module tmr_shared_core
    import tmr_pkg::*;
#(
    parameter int unsigned         ADDR_W     = 5,
    parameter int unsigned         WORD_W     = 32,
    parameter int unsigned         NUM_CH     = 8,
    parameter logic [2*WORD_W-1:0] COUNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] chan_irq,
    output logic              tick_o,
    output logic              irq_any_o
);

    localparam int unsigned CNT_W = 2 * WORD_W;

    logic              cfg_cnt_en;
    logic              cfg_ps_en;
    logic [WORD_W-1:0] reload_q;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;
    logic              lo_rd;
    logic              hi_rd;
    logic [CNT_W-1:0]  count_q;

    tmr_regfile #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .NUM_CH(NUM_CH)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .chan_irq (chan_irq),
        .lo_word  (lo_word),
        .hi_word  (hi_word),
        .lo_rd    (lo_rd),
        .hi_rd    (hi_rd),
        .cnt_en   (cfg_cnt_en),
        .ps_en    (cfg_ps_en),
        .reload   (reload_q)
    );

    tmr_prescaler #(
        .DIV_W(WORD_W)
    ) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_ps_en),
        .divisor(reload_q),
        .tick   (tick_o)
    );

    tmr_freerun #(
        .WORD_W    (WORD_W),
        .COUNT_INIT(COUNT_INIT)
    ) frc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(cfg_cnt_en),
        .lo_rd   (lo_rd),
        .hi_rd   (hi_rd),
        .lo_word (lo_word),
        .hi_word (hi_word),
        .count   (count_q)
    );

    always_comb begin
        irq_any_o = |chan_irq;
    end

endmodule

// File: rtl/tmr_shared_core_chk.sv
module tmr_shared_core_chk
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NUM_CH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                ps_en,
    input logic                cnt_en,
    input logic [2*WORD_W-1:0] count,
    input logic [WORD_W-1:0]   reload,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [WORD_W-1:0]   rdata,
    input logic [NUM_CH-1:0]   chan_irq
);

    // R5
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ps_en);

    // R4
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0) |=> (!tick || reload == '0));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> count == $past(count) + 1'b1);

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> count == $past(count));

    // R9
    split_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_CNT_LO)) ##1 (rd_en && addr == ADDR_W'(OFF_CNT_HI))
        |=> rdata == $past(count[2*WORD_W-1:WORD_W], 2));

    // R10
    irq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_IRQ)) |=> rdata == WORD_W'($past(chan_irq)));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind tmr_shared_core tmr_shared_core_chk #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .NUM_CH(NUM_CH)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_o),
    .ps_en   (cfg_ps_en),
    .cnt_en  (cfg_cnt_en),
    .count   (count_q),
    .reload  (reload_q),
    .rd_en   (reg_rd),
    .addr    (reg_addr),
    .rdata   (reg_rdata),
    .chan_irq(chan_irq)
);

// File: tb/tmr_shared_core_tb_top.sv
module tmr_shared_core_tb_top;

    localparam logic [63:0] INIT = 64'hFFFF_FFFF_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  chan_irq = '0;
    logic        tick_o;
    logic        irq_any_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr_shared_core #(.COUNT_INIT(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_irq(chan_irq), .tick_o(tick_o), .irq_any_o(irq_any_o)
    );

    // bench model of the counter, from R7/R8 and the bench's own writes
    logic [63:0] cnt_m;
    logic        cnt_on_m;
    logic [31:0] shadow_m = '0;
    logic        held_m = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_m    <= INIT;
            cnt_on_m <= 1'b0;
        end else begin
            if (cnt_on_m) cnt_m <= cnt_m + 64'd1;
            if (reg_wr && reg_addr == 5'h08) cnt_on_m <= reg_wdata[0];
        end
    end

    // scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always @(posedge clk) rd_pend <= reg_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: reg_rdata=%h expected=%h", t, reg_rdata, e);
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
    endtask

    // all tasks start and end at a negedge
    task automatic do_read(input logic [4:0] a, input logic [31:0] e, input string t);
        reg_addr = a;
        reg_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic read_lo(input string t);
        shadow_m = cnt_m[63:32];
        held_m   = 1'b1;
        do_read(5'h10, cnt_m[31:0], t);
    endtask

    task automatic read_hi(input string t);
        logic [31:0] e;
        e      = held_m ? shadow_m : cnt_m[63:32];
        held_m = 1'b0;
        do_read(5'h14, e, t);
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // negedges until tick seen (capped)
    task automatic wait_tick(output int k);
        k = 0;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (tick_o) begin
                k = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k;
        int ticks;
        logic [31:0] last;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 tick", 32'(tick_o), 32'd0);
        check("R1 irq_any", 32'(irq_any_o), 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        do_read(5'h04, 32'd0, "R1 reload reset");
        do_read(5'h08, 32'd0, "R1 config reset");
        read_lo("R1 count low init");
        read_hi("R1 count high init");

        // R3 reload readback
        do_write(5'h04, 32'hA5C3_0F96);
        do_read(5'h04, 32'hA5C3_0F96, "R3 reload full width");
        do_write(5'h04, 32'd3);

        // R2 config: only bits 0 and 2 stored; R4 first tick after N+1
        do_write(5'h08, 32'hFFFF_FFFF);
        wait_tick(k);
        check("R4 first tick after enable", k, 32'd4);
        @(negedge clk);
        check("R4 tick one cycle wide", 32'(tick_o), 32'd0);
        wait_tick(k);
        check("R4 tick period N+1", k, 32'd3);
        wait_tick(k);
        check("R4 tick period N+1 again", k, 32'd4);
        do_read(5'h08, 32'h0000_0005, "R2 config readback");

        // R8/R9 coherent split read across the wrap
        while (cnt_m != 64'hFFFF_FFFF_FFFF_FFFC) @(negedge clk);
        read_lo("R9 low word before wrap");
        idle(10);
        read_hi("R8 R9 high word from shadow after wrap");
        read_hi("R9 high word live in idle");
        read_lo("R8 low word after wrap");
        read_lo("R9 low recapture");
        read_hi("R9 high after recapture");

        // R7 hold while counter gate clear
        do_write(5'h08, 32'h0000_0004);
        idle(2);
        read_lo("R7 held low word");
        idle(7);
        read_lo("R7 held low word unchanged");
        read_hi("R7 held high word");

        // R5 no tick while prescaler disabled, restart on enable
        do_write(5'h08, 32'h0000_0001);
        ticks = 0;
        for (int i = 0; i < 20; i++) begin
            if (tick_o) ticks++;
            @(negedge clk);
        end
        check("R5 no tick while disabled", ticks, 32'd0);
        do_write(5'h08, 32'h0000_0005);
        wait_tick(k);
        check("R5 phase restart after enable", k, 32'd4);

        // R6 lowering N below the running count
        do_write(5'h04, 32'd20);
        idle(8);
        do_write(5'h04, 32'd3);
        check("R6 immediate tick on lowered N", 32'(tick_o), 32'd1);
        wait_tick(k);
        check("R6 period after lowered N", k, 32'd4);

        // R10 interrupt view
        chan_irq = 8'h40;
        idle(1);
        check("R10 irq_any single line", 32'(irq_any_o), 32'd1);
        do_read(5'h0C, 32'h0000_0040, "R10 irq status");
        chan_irq = 8'h81;
        do_read(5'h0C, 32'h0000_0081, "R10 irq status two lines");
        chan_irq = 8'h00;
        idle(1);
        check("R10 irq_any none", 32'(irq_any_o), 32'd0);

        // R11 unmapped read and hold
        do_read(5'h1C, 32'd0, "R11 unmapped reads zero");
        do_read(5'h04, 32'd3, "R11 read before hold");
        last = reg_rdata;
        idle(4);
        check("R11 rdata held without read", reg_rdata, last);

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule